// File: doc/BRIEF.md
# SDRAM Power-Up Command Sequencer

This block owns the SDRAM command pins from reset until the memory is usable. While reset is held it keeps clock enable low and the chip deselected. After reset it raises clock enable, drives no-operation commands through a parameterised settling delay, and then issues a fixed script. The script is one precharge covering every bank, two auto-refresh commands and one mode-register load. The op-code of the mode load is assembled from configuration inputs for burst length, burst type, read latency and write-burst behaviour.

Every delay and command spacing is given in nanoseconds and turned into clock counts from the clock period parameter, rounding up. When the final spacing after the mode load has passed, the block raises `init_done` and leaves the bus in no-operation. If the configuration asks for a reserved burst length or read latency, the block stops before the mode load and raises `init_error`. The memory controller that follows takes over the pins once `init_done` is high.

Top module: `sdram_powerup_seq`

## Requirements
- R1: While `rst_n` is low, `sd_cke` is 0, `sd_cs_n` is 1, and `init_done` and `init_error` are 0.
- R2: On the first clock edge after reset is released, `sd_cke` rises. Every cycle from then until the first command carries NOP ({cs_n,ras_n,cas_n,we_n} = 0111). The precharge appears after exactly PWR_CYC+1 such cycles, where PWR_CYC = ceil(POWERUP_NS*1000/CLK_PERIOD_PS).
- R3: The commands other than NOP are issued in this order and only once each: precharge, refresh, refresh, mode load. Nothing but NOP follows them.
- R4: The precharge is encoded {cs_n,ras_n,cas_n,we_n} = 0010 with address bit 10 high, so that it covers all banks.
- R5: The first refresh follows the precharge by RP_CYC clocks, and the second refresh follows the first by RC_CYC clocks. Each count is ceil(ns*1000/CLK_PERIOD_PS), with a minimum of 2.
- R6: A refresh is encoded 0001 and the mode load 0000. The mode load follows the second refresh by RC_CYC clocks.
- R7: During the mode load, the address carries burst length in bits 2:0, burst type in bit 3, latency code in bits 6:4, zeros in bits 8:7, the write-single flag in bit 9 and zeros in bits 11:10.
- R8: `init_done` rises exactly MRD_CYC clocks after the mode load (MRD_CYC = max(TMRD_CLK,2)) and then stays high.
- R9: Legal burst-length codes are 000, 001, 010 and 011 with either burst type, and 111 only with sequential type (bit 3 = 0). Legal latency codes are 010 and 011. With any other configuration, no mode load is issued, `init_error` rises RC_CYC clocks after the second refresh and stays high, and `init_done` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_burst_len | input | 3 | Burst-length code for the mode op-code |
| cfg_burst_type | input | 1 | 0 sequential, 1 interleaved |
| cfg_cas_lat | input | 3 | Read-latency code (010 or 011) |
| cfg_write_single | input | 1 | 1 makes writes single-location |
| sd_cke | output | 1 | Clock enable to the memory |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W | Address / op-code bus |
| sd_ba | output | BA_W | Bank select, held at zero |
| init_done | output | 1 | Sequence complete, memory ready |
| init_error | output | 1 | Reserved configuration, sequence halted |

## Verification
A wrong state or a wrong count in the sequencer becomes visible on the command pins at the next command edge. The symptom is a command out of order, a spacing that is one clock short or long, or a precharge whose bank-select bit 10 is clear. A wrong field placement in the op-code shows up as a wrong address value in the single cycle of the mode load. A legality decision that goes the wrong way shows up RC_CYC clocks after the second refresh: a mode load appears where the error flag should rise, or the flag rises where a mode load should appear. Each run logs every command cycle by cycle and compares the log against counts the bench derives itself from the nanosecond parameters.

// File: rtl/sdr_init_pkg.sv
package sdr_init_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_LMR = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111,
    CMD_INH = 4'b1111
  } sdr_cmd_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CKE,
    ST_PWR,
    ST_PRE,
    ST_TRP,
    ST_REF1,
    ST_TRC1,
    ST_REF2,
    ST_TRC2,
    ST_LMR,
    ST_TMRD,
    ST_DONE,
    ST_ERR
  } seq_state_e;

  // Nanoseconds to whole clocks, rounded up, with a lower bound.
  function automatic int unsigned ns_to_cyc(input int unsigned ns,
                                            input int unsigned period_ps,
                                            input int unsigned min_cyc);
    int unsigned c;
    c = (ns * 1000 + period_ps - 1) / period_ps;
    return (c < min_cyc) ? min_cyc : c;
  endfunction

  function automatic int unsigned max3(input int unsigned a,
                                       input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  function automatic logic burst_len_ok(input logic [2:0] bl, input logic bt);
    return (bl[2] == 1'b0) || (bl == 3'b111 && bt == 1'b0);
  endfunction

  function automatic logic cas_code_ok(input logic [2:0] cl);
    return (cl == 3'b010) || (cl == 3'b011);
  endfunction

  function automatic logic [11:0] make_opcode(input logic [2:0] bl,
                                              input logic       bt,
                                              input logic [2:0] cl,
                                              input logic       ws);
    logic [11:0] op;
    op        = '0;
    op[2:0]   = bl;
    op[3]     = bt;
    op[6:4]   = cl;
    op[9]     = ws;
    return op;
  endfunction

endpackage

// File: rtl/sdr_wait_timer.sv
module sdr_wait_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sdr_mode_word.sv
module sdr_mode_word
  import sdr_init_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic [2:0]        bl,
  input  logic              bt,
  input  logic [2:0]        cl,
  input  logic              ws,
  output logic [ADDR_W-1:0] opcode,
  output logic              cfg_ok
);

  logic [11:0] op12;

  assign op12 = make_opcode(bl, bt, cl, ws);

  generate
    if (ADDR_W > 12) begin : g_pad
      assign opcode = {{(ADDR_W-12){1'b0}}, op12};
    end else begin : g_fit
      assign opcode = op12[ADDR_W-1:0];
    end
  endgenerate

  assign cfg_ok = burst_len_ok(bl, bt) && cas_code_ok(cl);

endmodule

// File: rtl/sdr_cmd_fsm.sv
module sdr_cmd_fsm
  import sdr_init_pkg::*;
#(
  parameter int unsigned PWR_CYC = 16,
  parameter int unsigned RP_CYC  = 3,
  parameter int unsigned RC_CYC  = 10,
  parameter int unsigned MRD_CYC = 2,
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned ADDR_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              expired,
  input  logic              cfg_ok,
  input  logic [ADDR_W-1:0] opcode,
  output logic              timer_load,
  output logic [CNT_W-1:0]  timer_val,
  output logic              cke,
  output logic [3:0]        cmd,
  output logic [ADDR_W-1:0] addr,
  output logic              done,
  output logic              err
);

  localparam logic [CNT_W-1:0] PWR_LD = CNT_W'(PWR_CYC - 1);
  localparam logic [CNT_W-1:0] RP_LD  = CNT_W'(RP_CYC - 2);
  localparam logic [CNT_W-1:0] RC_LD  = CNT_W'(RC_CYC - 2);
  localparam logic [CNT_W-1:0] MRD_LD = CNT_W'(MRD_CYC - 2);
  localparam logic [ADDR_W-1:0] ALL_BANKS = ADDR_W'(1) << 10;

  seq_state_e state_q, state_d;

  function automatic logic [3:0] cmd_of(input seq_state_e s);
    case (s)
      ST_IDLE:         return CMD_INH;
      ST_PRE:          return CMD_PRE;
      ST_REF1, ST_REF2: return CMD_REF;
      ST_LMR:          return CMD_LMR;
      default:         return CMD_NOP;
    endcase
  endfunction

  always_comb begin
    state_d    = state_q;
    timer_load = 1'b0;
    timer_val  = '0;
    case (state_q)
      ST_IDLE: state_d = ST_CKE;
      ST_CKE: begin
        state_d = ST_PWR; timer_load = 1'b1; timer_val = PWR_LD;
      end
      ST_PWR:  if (expired) state_d = ST_PRE;
      ST_PRE: begin
        state_d = ST_TRP; timer_load = 1'b1; timer_val = RP_LD;
      end
      ST_TRP:  if (expired) state_d = ST_REF1;
      ST_REF1: begin
        state_d = ST_TRC1; timer_load = 1'b1; timer_val = RC_LD;
      end
      ST_TRC1: if (expired) state_d = ST_REF2;
      ST_REF2: begin
        state_d = ST_TRC2; timer_load = 1'b1; timer_val = RC_LD;
      end
      ST_TRC2: if (expired) state_d = cfg_ok ? ST_LMR : ST_ERR;
      ST_LMR: begin
        state_d = ST_TMRD; timer_load = 1'b1; timer_val = MRD_LD;
      end
      ST_TMRD: if (expired) state_d = ST_DONE;
      ST_DONE: state_d = ST_DONE;
      ST_ERR:  state_d = ST_ERR;
      default: state_d = ST_IDLE;
    endcase
  end

  // Pin outputs are registered from the next state so they align with it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cke     <= 1'b0;
      cmd     <= CMD_INH;
      addr    <= '0;
      done    <= 1'b0;
      err     <= 1'b0;
    end else begin
      state_q <= state_d;
      cke     <= (state_d != ST_IDLE);
      cmd     <= cmd_of(state_d);
      addr    <= (state_d == ST_PRE) ? ALL_BANKS :
                 (state_d == ST_LMR) ? opcode : '0;
      done    <= (state_d == ST_DONE);
      err     <= (state_d == ST_ERR);
    end
  end

endmodule

// File: rtl/sdram_powerup_seq.sv
module sdram_powerup_seq
  import sdr_init_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS = 8000,
  parameter int unsigned POWERUP_NS    = 100000,
  parameter int unsigned TRP_NS        = 24,
  parameter int unsigned TRC_NS        = 80,
  parameter int unsigned TMRD_CLK      = 2,
  parameter int unsigned ADDR_W        = 12,
  parameter int unsigned BA_W          = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cfg_burst_len,
  input  logic              cfg_burst_type,
  input  logic [2:0]        cfg_cas_lat,
  input  logic              cfg_write_single,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [ADDR_W-1:0] sd_addr,
  output logic [BA_W-1:0]   sd_ba,
  output logic              init_done,
  output logic              init_error
);

  localparam int unsigned PWR_CYC = ns_to_cyc(POWERUP_NS, CLK_PERIOD_PS, 1);
  localparam int unsigned RP_CYC  = ns_to_cyc(TRP_NS, CLK_PERIOD_PS, 2);
  localparam int unsigned RC_CYC  = ns_to_cyc(TRC_NS, CLK_PERIOD_PS, 2);
  localparam int unsigned MRD_CYC = (TMRD_CLK < 2) ? 2 : TMRD_CLK;
  localparam int unsigned MAX_CYC = max3(PWR_CYC, max3(RP_CYC, RC_CYC, MRD_CYC), 1);
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  // Named internal events
  logic              cfg_ok;
  logic              wait_expired;
  logic              timer_load;
  logic [CNT_W-1:0]  timer_val;
  logic [ADDR_W-1:0] mode_opcode;
  logic [3:0]        cmd_bits;

  sdr_mode_word #(.ADDR_W(ADDR_W)) u_mode (
    .bl     (cfg_burst_len),
    .bt     (cfg_burst_type),
    .cl     (cfg_cas_lat),
    .ws     (cfg_write_single),
    .opcode (mode_opcode),
    .cfg_ok (cfg_ok)
  );

  sdr_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (timer_load),
    .load_val (timer_val),
    .expired  (wait_expired)
  );

  sdr_cmd_fsm #(
    .PWR_CYC (PWR_CYC),
    .RP_CYC  (RP_CYC),
    .RC_CYC  (RC_CYC),
    .MRD_CYC (MRD_CYC),
    .CNT_W   (CNT_W),
    .ADDR_W  (ADDR_W)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .expired    (wait_expired),
    .cfg_ok     (cfg_ok),
    .opcode     (mode_opcode),
    .timer_load (timer_load),
    .timer_val  (timer_val),
    .cke        (sd_cke),
    .cmd        (cmd_bits),
    .addr       (sd_addr),
    .done       (init_done),
    .err        (init_error)
  );

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_bits;
  assign sd_ba = '0;

endmodule

// File: rtl/sdram_powerup_seq_chk.sv
module sdram_powerup_seq_chk #(
  parameter int unsigned PWR_CYC = 16,
  parameter int unsigned RP_CYC  = 3,
  parameter int unsigned RC_CYC  = 10,
  parameter int unsigned MRD_CYC = 2,
  parameter int unsigned ADDR_W  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sd_cke,
  input logic              sd_cs_n,
  input logic              sd_ras_n,
  input logic              sd_cas_n,
  input logic              sd_we_n,
  input logic [ADDR_W-1:0] sd_addr,
  input logic              init_done,
  input logic              init_error
);

  logic [3:0]  cmd4;
  logic        active;
  logic        first_seen;
  logic        lmr_seen;
  logic        last_valid;
  logic [3:0]  last_cmd;
  int unsigned nop_run;
  int unsigned since;

  assign cmd4   = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
  assign active = !sd_cs_n && (cmd4 != 4'b0111);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_seen <= 1'b0;
      lmr_seen   <= 1'b0;
      last_valid <= 1'b0;
      last_cmd   <= 4'b0111;
      nop_run    <= 0;
      since      <= 0;
    end else begin
      if (active) begin
        first_seen <= 1'b1;
        last_valid <= 1'b1;
        last_cmd   <= cmd4;
        since      <= 1;
        if (cmd4 == 4'b0000) lmr_seen <= 1'b1;
      end else if (since < 32'hFFFF_0000) begin
        since <= since + 1;
      end
      if (sd_cke && !active && !first_seen && nop_run < 32'hFFFF_0000)
        nop_run <= nop_run + 1;
    end
  end

  a_r1_cke_low_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    !sd_cke |-> sd_cs_n);

  a_r2_powerup_nops: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !first_seen) |-> (nop_run >= PWR_CYC));

  a_r4_pre_all_banks: assert property (@(posedge clk) disable iff (!rst_n)
    (!sd_cs_n && cmd4 == 4'b0010) |-> sd_addr[10]);

  a_r5_trp_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (active && last_valid && last_cmd == 4'b0010) |-> (since >= RP_CYC));

  a_r5_trc_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (active && last_valid && last_cmd == 4'b0001) |-> (since >= RC_CYC));

  a_r7_opcode_fields: assert property (@(posedge clk) disable iff (!rst_n)
    (!sd_cs_n && cmd4 == 4'b0000) |->
      (sd_addr[11:10] == 2'b00 && sd_addr[8:7] == 2'b00 &&
       (sd_addr[6:4] == 3'b010 || sd_addr[6:4] == 3'b011)));

  a_r8_mrd_before_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> (lmr_seen && since >= MRD_CYC));

  a_r8_ready_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(init_done && init_error));

  a_r9_no_load_on_error: assert property (@(posedge clk) disable iff (!rst_n)
    init_error |-> !lmr_seen);

endmodule

bind sdram_powerup_seq sdram_powerup_seq_chk #(
  .PWR_CYC (PWR_CYC),
  .RP_CYC  (RP_CYC),
  .RC_CYC  (RC_CYC),
  .MRD_CYC (MRD_CYC),
  .ADDR_W  (ADDR_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sd_cke     (sd_cke),
  .sd_cs_n    (sd_cs_n),
  .sd_ras_n   (sd_ras_n),
  .sd_cas_n   (sd_cas_n),
  .sd_we_n    (sd_we_n),
  .sd_addr    (sd_addr),
  .init_done  (init_done),
  .init_error (init_error)
);

// File: tb/tb_sdram_powerup_seq.sv
`timescale 1ns/1ps
module tb_sdram_powerup_seq;

  localparam int PERIOD_PS = 8000;
  localparam int PWRUP_NS  = 1000;
  // Expected counts, derived here from the requirement formulas.
  localparam int E_PWR = (PWRUP_NS * 1000 + PERIOD_PS - 1) / PERIOD_PS;
  localparam int E_RP  = (24 * 1000 + PERIOD_PS - 1) / PERIOD_PS;
  localparam int E_RC  = (80 * 1000 + PERIOD_PS - 1) / PERIOD_PS;
  localparam int E_MRD = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cfg_bl = 3'b000;
  logic        cfg_bt = 1'b0;
  logic [2:0]  cfg_cl = 3'b010;
  logic        cfg_ws = 1'b0;
  logic        sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [11:0] sd_addr;
  logic [0:0]  sd_ba;
  logic        init_done, init_error;

  always #4 clk = ~clk;

  sdram_powerup_seq #(
    .CLK_PERIOD_PS (PERIOD_PS),
    .POWERUP_NS    (PWRUP_NS)
  ) dut (
    .clk              (clk),
    .rst_n            (rst_n),
    .cfg_burst_len    (cfg_bl),
    .cfg_burst_type   (cfg_bt),
    .cfg_cas_lat      (cfg_cl),
    .cfg_write_single (cfg_ws),
    .sd_cke           (sd_cke),
    .sd_cs_n          (sd_cs_n),
    .sd_ras_n         (sd_ras_n),
    .sd_cas_n         (sd_cas_n),
    .sd_we_n          (sd_we_n),
    .sd_addr          (sd_addr),
    .sd_ba            (sd_ba),
    .init_done        (init_done),
    .init_error       (init_error)
  );

  int checks = 0;
  int errors = 0;
  int tick   = 0;
  int cyc    = 0;
  bit mon_on = 1'b0;
  int nlog, inh_bad, done_idx, err_idx;
  logic [3:0]  lg_cmd  [0:15];
  int          lg_cyc  [0:15];
  logic [11:0] lg_addr [0:15];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    tick++;
    if (mon_on) begin
      if (sd_cs_n || !sd_cke) inh_bad++;
      else if ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} != 4'b0111) begin
        if (nlog < 16) begin
          lg_cmd[nlog]  = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
          lg_cyc[nlog]  = cyc;
          lg_addr[nlog] = sd_addr;
        end
        nlog++;
      end
      if (init_done && done_idx < 0) done_idx = cyc;
      if (init_error && err_idx < 0) err_idx = cyc;
      cyc++;
    end
  end

  task automatic start_run(input logic [2:0] bl, input logic bt,
                           input logic [2:0] cl, input logic ws);
    mon_on = 1'b0;
    rst_n  = 1'b0;
    cfg_bl = bl; cfg_bt = bt; cfg_cl = cl; cfg_ws = ws;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(sd_cke == 1'b0,  "R1 cke in reset", sd_cke, 0);
    chk(sd_cs_n == 1'b1, "R1 cs_n in reset", sd_cs_n, 1);
    chk(!init_done && !init_error, "R1 flags in reset", {init_done, init_error}, 0);
    nlog = 0; inh_bad = 0; done_idx = -1; err_idx = -1; cyc = 0;
    #1 rst_n = 1'b1;
    mon_on = 1'b1;
    while (cyc < E_PWR + E_RP + 2 * E_RC + E_MRD + 30) @(negedge clk);
  endtask

  task automatic check_head();
    // R2: NOP with CKE high until the precharge, exact count
    chk(inh_bad == 0, "R2 non-NOP idle cycles", inh_bad, 0);
    chk(lg_cmd[0] == 4'b0010, "R4 first command is precharge", lg_cmd[0], 4'b0010);
    chk(lg_cyc[0] == E_PWR + 1, "R2 precharge position", lg_cyc[0], E_PWR + 1);
    chk(lg_addr[0][10] == 1'b1, "R4 precharge A10", lg_addr[0][10], 1);
    chk(lg_cmd[1] == 4'b0001 && lg_cmd[2] == 4'b0001, "R6 refresh encoding",
        {lg_cmd[1], lg_cmd[2]}, 8'h11);
    chk(lg_cyc[1] - lg_cyc[0] == E_RP, "R5 precharge to refresh", lg_cyc[1] - lg_cyc[0], E_RP);
    chk(lg_cyc[2] - lg_cyc[1] == E_RC, "R5 refresh to refresh", lg_cyc[2] - lg_cyc[1], E_RC);
  endtask

  task automatic run_good(input logic [2:0] bl, input logic bt,
                          input logic [2:0] cl, input logic ws);
    int exp_op;
    start_run(bl, bt, cl, ws);
    check_head();
    exp_op = (int'(ws) << 9) | (int'(cl) << 4) | (int'(bt) << 3) | int'(bl);
    chk(nlog == 4, "R3 command count", nlog, 4);
    chk(lg_cmd[3] == 4'b0000, "R6 mode load encoding", lg_cmd[3], 0);
    chk(lg_cyc[3] - lg_cyc[2] == E_RC, "R6 refresh to mode load", lg_cyc[3] - lg_cyc[2], E_RC);
    chk(int'(lg_addr[3]) == exp_op, "R7 op-code", lg_addr[3], exp_op);
    chk(done_idx == lg_cyc[3] + E_MRD, "R8 ready timing", done_idx, lg_cyc[3] + E_MRD);
    chk(init_done && !init_error, "R8 ready held", {init_done, init_error}, 2);
  endtask

  task automatic run_bad(input logic [2:0] bl, input logic bt,
                         input logic [2:0] cl, input logic ws);
    start_run(bl, bt, cl, ws);
    check_head();
    chk(nlog == 3, "R9 no mode load on reserved config", nlog, 3);
    chk(err_idx == lg_cyc[2] + E_RC, "R9 error timing", err_idx, lg_cyc[2] + E_RC);
    chk(init_error && !init_done, "R9 error held, not ready", {init_done, init_error}, 1);
  endtask

  initial begin
    run_good(3'b011, 1'b0, 3'b010, 1'b0);  // burst 8 sequential, latency 2
    run_good(3'b111, 1'b0, 3'b011, 1'b1);  // full page sequential, write single
    run_good(3'b010, 1'b1, 3'b011, 1'b0);  // burst 4 interleaved
    run_good(3'b000, 1'b1, 3'b010, 1'b1);  // burst 1
    run_bad (3'b111, 1'b1, 3'b010, 1'b0);  // full page interleaved is reserved
    run_bad (3'b100, 1'b0, 3'b011, 1'b0);  // reserved burst length
    run_bad (3'b001, 1'b0, 3'b001, 1'b0);  // reserved latency code
    run_bad (3'b001, 1'b0, 3'b100, 1'b1);  // reserved latency code
    // R1 again: reset in the middle of a finished sequence clears outputs
    run_good(3'b001, 1'b0, 3'b011, 1'b0);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!sd_cke && sd_cs_n && !init_done, "R1 reset after ready",
        {sd_cke, sd_cs_n, init_done}, 3'b010);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (tick > 60000);
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected below 60000", tick);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule